// File: doc/BRIEF.md
# Programmable-Delay Shifter Input Stage

This block sits in front of a lookup-table path inside a flexible serial engine. One bit of a pin bus is picked by a select field and pushed into a shift line of up to 32 stages. A width field picks the tap on that line, so the picked pin reaches the lookup table after a programmable number of clocks. The smallest width gives the longest delay, and the delay shrinks as the width grows.

The same block watches the pin that the lookup table drives. That pin is passed through a two-flop synchronizer. The synchronized level drives a status flag that simply follows it, and an error flag that latches a high level. The error flag stays set until software writes a one to it. The status flag is brought out a second time as a trigger for a timer. Interrupt and DMA request outputs are the flags gated by their enables. The lookup-table logic and the register decode are outside the block. A clear is seen here as a write strobe plus the written data bit.

Top module: `tapline_input_stage`

## Requirements
- R1: With `width` equal to 0, `lut_in` equals the selected pin value that was sampled 32 rising clock edges earlier (the register fed on an edge counts as 1).
- R2: With `width` in 16..31, `lut_in` equals the selected pin value sampled on the previous rising edge (1 stage).
- R3: With `width` in 1..15, the delay in stages is 32 - 2*width, and never less than 1 (for example, width 1 gives 30 and width 15 gives 2).
- R4: The bit fed into the delay line is `pin_vec[pin_sel]`, where `pin_sel` is a binary index into the pin bus.
- R5: `stat_flag` equals the level `lut_pin` had two rising edges earlier (two-flop synchronizer). It is 1 while that level is 1 and 0 while it is 0.
- R6: `stat_trig` always equals `stat_flag`. `stat_irq` is `stat_flag` AND `stat_irq_en`. `stat_dma` is `stat_flag` AND `stat_dma_en`.
- R7: `err_flag` becomes 1 on the edge after `stat_flag` is 1. It stays 1 until an edge where `err_clr_wr` is 1 and `err_clr_data` is 1. A write whose data bit is 0 has no effect. `err_irq` is `err_flag` AND `err_irq_en`.
- R8: When a clearing write and a set condition (`stat_flag` = 1) occur in the same cycle, `err_flag` stays 1.
- R9: While `rst_n` is 0, the delay line holds all zeros (`lut_in` = 0) and both flags and the synchronizer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_vec | input | 8 | Pin bus that offers inputs to the delay line |
| pin_sel | input | 3 | Index of the pin fed into the delay line |
| width | input | 5 | Width setting that chooses the delay tap |
| lut_pin | input | 1 | Lookup-table output pin being observed (asynchronous) |
| err_clr_wr | input | 1 | Write strobe to the error flag |
| err_clr_data | input | 1 | Data bit of that write; 1 clears |
| stat_irq_en | input | 1 | Status interrupt enable |
| stat_dma_en | input | 1 | Status DMA request enable |
| err_irq_en | input | 1 | Error interrupt enable |
| lut_in | output | 1 | Delayed pin value toward the lookup table |
| stat_flag | output | 1 | Status flag (synchronized pin level) |
| stat_trig | output | 1 | Status flag as timer trigger |
| stat_irq | output | 1 | Status interrupt request |
| stat_dma | output | 1 | Status DMA request |
| err_flag | output | 1 | Sticky error flag |
| err_irq | output | 1 | Error interrupt request |

## Verification
The properties assume reset is applied once, from time zero, and that all inputs change away from the rising edge. The one-stage delay property compares against the selected pin one edge back, so it relies on `pin_sel` and `pin_vec` being stable across each edge. The bench changes every input one nanosecond after a rising edge and only releases reset after several clocks. It sweeps the width through its three ranges while drawing pins, select values, enables and clearing writes at random. Directed sequences then cover clears with data 0, clears while the pin is low, and clears that collide with a high pin.

// File: rtl/tapline_pkg.sv
package tapline_pkg;

    // Delay in stages for a width setting, given the line length.
    function automatic int unsigned tap_depth(input int unsigned w, input int unsigned max_depth);
        int unsigned d;
        if (w == 0)
            d = max_depth;
        else if (w >= max_depth / 2)
            d = 1;
        else if (max_depth > 2 * w)
            d = max_depth - 2 * w;
        else
            d = 1;
        if (d < 1)
            d = 1;
        return d;
    endfunction

    typedef struct packed {
        logic err;
    } flag_state_t;

endpackage

// File: rtl/tapline_delay.sv
module tapline_delay #(
    parameter int MAXDEPTH = 32,
    parameter int WW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [WW-1:0] width,
    output logic          dout
);
    import tapline_pkg::*;

    localparam int TAPW = $clog2(MAXDEPTH);

    typedef struct packed {
        logic [MAXDEPTH-1:0] line;
    } dly_state_t;

    dly_state_t    st_d, st_q;
    logic [TAPW-1:0] tap_idx;

    always_comb begin
        st_d      = st_q;
        st_d.line = {st_q.line[MAXDEPTH-2:0], din};
        tap_idx   = TAPW'(tap_depth(int'(width), MAXDEPTH) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dout = st_q.line[tap_idx];

endmodule

// File: rtl/tapline_sync.sv
module tapline_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/tapline_flags.sv
module tapline_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic clr_wr,
    input  logic clr_data,
    input  logic stat_irq_en,
    input  logic stat_dma_en,
    input  logic err_irq_en,
    output logic stat_flag,
    output logic stat_trig,
    output logic stat_irq,
    output logic stat_dma,
    output logic err_flag,
    output logic err_irq
);
    import tapline_pkg::*;

    flag_state_t st_d, st_q;
    logic        clr_hit;

    always_comb begin
        st_d    = st_q;
        clr_hit = clr_wr & clr_data;
        if (level)
            st_d.err = 1'b1;
        else if (clr_hit)
            st_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign stat_flag = level;
    assign stat_trig = level;
    assign stat_irq  = level & stat_irq_en;
    assign stat_dma  = level & stat_dma_en;
    assign err_flag  = st_q.err;
    assign err_irq   = st_q.err & err_irq_en;

endmodule

// File: rtl/tapline_input_stage.sv
module tapline_input_stage #(
    parameter int NPIN     = 8,
    parameter int MAXDEPTH = 32,
    parameter int WW       = 5,
    parameter int SYNC_N   = 2,
    localparam int SELW    = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_vec,
    input  logic [SELW-1:0] pin_sel,
    input  logic [WW-1:0]   width,
    input  logic            lut_pin,
    input  logic            err_clr_wr,
    input  logic            err_clr_data,
    input  logic            stat_irq_en,
    input  logic            stat_dma_en,
    input  logic            err_irq_en,
    output logic            lut_in,
    output logic            stat_flag,
    output logic            stat_trig,
    output logic            stat_irq,
    output logic            stat_dma,
    output logic            err_flag,
    output logic            err_irq
);
    logic sel_bit;
    logic pin_sync;

    assign sel_bit = pin_vec[pin_sel];

    tapline_delay #(.MAXDEPTH(MAXDEPTH), .WW(WW)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sel_bit),
        .width (width),
        .dout  (lut_in)
    );

    tapline_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lut_pin),
        .dout  (pin_sync)
    );

    tapline_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (pin_sync),
        .clr_wr      (err_clr_wr),
        .clr_data    (err_clr_data),
        .stat_irq_en (stat_irq_en),
        .stat_dma_en (stat_dma_en),
        .err_irq_en  (err_irq_en),
        .stat_flag   (stat_flag),
        .stat_trig   (stat_trig),
        .stat_irq    (stat_irq),
        .stat_dma    (stat_dma),
        .err_flag    (err_flag),
        .err_irq     (err_irq)
    );

endmodule

// File: rtl/tapline_input_stage_chk.sv
module tapline_input_stage_chk #(
    parameter int NPIN = 8,
    parameter int WW   = 5,
    localparam int SELW = $clog2(NPIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NPIN-1:0] pin_vec,
    input logic [SELW-1:0] pin_sel,
    input logic [WW-1:0]   width,
    input logic            lut_pin,
    input logic            err_clr_wr,
    input logic            err_clr_data,
    input logic            lut_in,
    input logic            stat_flag,
    input logic            stat_irq,
    input logic            stat_dma,
    input logic            err_flag,
    input logic            err_irq
);
    logic [1:0] live_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            live_cnt <= '0;
        else if (live_cnt != 2'd3)
            live_cnt <= live_cnt + 2'd1;
    end

    AST_STAT_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd2) |-> (stat_flag == $past(lut_pin, 2))); // R5

    AST_ONE_STAGE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd1 && int'(width) >= 16) |-> (lut_in == $past(pin_vec[pin_sel]))); // R2

    AST_STAT_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_flag |-> (!stat_irq && !stat_dma)); // R6

    AST_ERR_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_flag) |-> err_flag); // R7

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_flag) && !$past(err_clr_wr && err_clr_data)) |-> err_flag); // R7

    AST_ERR_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag |-> !err_irq); // R7

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_flag && err_clr_wr && err_clr_data) |-> err_flag); // R8

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_clr_wr && err_clr_data) && !$past(stat_flag)) |-> !err_flag); // R7

endmodule

bind tapline_input_stage tapline_input_stage_chk #(.NPIN(NPIN), .WW(WW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_vec      (pin_vec),
    .pin_sel      (pin_sel),
    .width        (width),
    .lut_pin      (lut_pin),
    .err_clr_wr   (err_clr_wr),
    .err_clr_data (err_clr_data),
    .lut_in       (lut_in),
    .stat_flag    (stat_flag),
    .stat_irq     (stat_irq),
    .stat_dma     (stat_dma),
    .err_flag     (err_flag),
    .err_irq      (err_irq)
);

// File: tb/tb_tapline_input_stage.sv
`timescale 1ns/1ps
module tb_tapline_input_stage;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_vec = '0;
    logic [2:0] pin_sel = '0;
    logic [4:0] width = '0;
    logic       lut_pin = 1'b0;
    logic       err_clr_wr = 1'b0;
    logic       err_clr_data = 1'b0;
    logic       stat_irq_en = 1'b0;
    logic       stat_dma_en = 1'b0;
    logic       err_irq_en = 1'b0;
    logic       lut_in, stat_flag, stat_trig, stat_irq, stat_dma, err_flag, err_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tapline_input_stage dut (
        .clk(clk), .rst_n(rst_n), .pin_vec(pin_vec), .pin_sel(pin_sel), .width(width),
        .lut_pin(lut_pin), .err_clr_wr(err_clr_wr), .err_clr_data(err_clr_data),
        .stat_irq_en(stat_irq_en), .stat_dma_en(stat_dma_en), .err_irq_en(err_irq_en),
        .lut_in(lut_in), .stat_flag(stat_flag), .stat_trig(stat_trig), .stat_irq(stat_irq),
        .stat_dma(stat_dma), .err_flag(err_flag), .err_irq(err_irq)
    );

    // Behavioural reference model
    bit hist[$];
    bit m_s1 = 0, m_s2 = 0, m_err = 0;

    function automatic int ref_delay(int w);
        if (w == 0) return 32;
        if (w >= 16) return 1;
        if (32 - 2 * w < 1) return 1;
        return 32 - 2 * w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_s1 = 0; m_s2 = 0; m_err = 0;
        end else begin
            hist.push_front(pin_vec[pin_sel]);
            if (hist.size() > 32) void'(hist.pop_back());
            if (m_s2) m_err = 1;
            else if (err_clr_wr && err_clr_data) m_err = 0;
            m_s2 = m_s1;
            m_s1 = lut_pin;
        end
    end

    task automatic check1(string tag, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int d;
            bit exp_lut;
            string lt, ft;
            d = ref_delay(int'(width));
            exp_lut = (hist.size() >= d) ? hist[d-1] : 1'b0;
            if (!rst_n) begin
                lt = "R9 lut_in"; ft = "R9";
            end else begin
                ft = "";
                if (width == 0) lt = "R1 R4 lut_in";
                else if (width >= 16) lt = "R2 R4 lut_in";
                else lt = "R3 R4 lut_in";
            end
            check1(lt, lut_in, exp_lut);
            check1({ft, " R5 stat_flag"}, stat_flag, m_s2);
            check1({ft, " R6 stat_trig"}, stat_trig, m_s2);
            check1({ft, " R6 stat_irq"}, stat_irq, m_s2 & stat_irq_en);
            check1({ft, " R6 stat_dma"}, stat_dma, m_s2 & stat_dma_en);
            check1({ft, " R7 R8 err_flag"}, err_flag, m_err);
            check1({ft, " R7 err_irq"}, err_irq, m_err & err_irq_en);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic random_phase(int w, int n, int pin_pct);
        width = 5'(w);
        for (int i = 0; i < n; i++) begin
            step();
            pin_vec      = 8'($urandom);
            pin_sel      = 3'($urandom);
            lut_pin      = (($urandom % 100) < pin_pct);
            err_clr_wr   = (($urandom % 4) == 0);
            err_clr_data = $urandom % 2;
            stat_irq_en  = $urandom % 2;
            stat_dma_en  = $urandom % 2;
            err_irq_en   = $urandom % 2;
        end
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        // R1: longest delay, then R3 mid widths, then R2 shortest
        random_phase(0, 80, 5);
        random_phase(1, 50, 5);
        random_phase(7, 40, 5);
        random_phase(15, 30, 5);
        random_phase(16, 30, 5);
        random_phase(31, 30, 5);
        // R4: walk each select index with a one-hot pattern at width 16
        width = 5'd16;
        for (int s = 0; s < 8; s++) begin
            step();
            pin_sel = 3'(s);
            pin_vec = 8'(1 << s);
        end
        // R7: directed error sequence
        step(); lut_pin = 0; err_clr_wr = 1; err_clr_data = 1; err_irq_en = 1;
        step(); err_clr_wr = 0;
        repeat (3) step();
        lut_pin = 1;
        step(); lut_pin = 0;
        repeat (4) step();
        err_clr_wr = 1; err_clr_data = 0;   // data 0: no effect
        step(); err_clr_wr = 0;
        repeat (2) step();
        err_clr_wr = 1; err_clr_data = 1;   // real clear
        step(); err_clr_wr = 0;
        repeat (2) step();
        // R8: clear held while pin high, set must win
        lut_pin = 1;
        repeat (3) step();
        err_clr_wr = 1; err_clr_data = 1;
        repeat (4) step();
        lut_pin = 0;
        repeat (4) step();
        err_clr_wr = 0;
        // mixed widths with sweeps of every setting
        for (int w = 0; w < 32; w++) random_phase(w, 12, 20);
        random_phase(0, 40, 30);
        repeat (2) step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule